// File: doc/BRIEF.md
# Double-Pumped Single-Port RAM Adapter

This block lets logic that runs at half the memory clock use one single-port synchronous SRAM as if it had two independent ports, A and B. The RAM clock `clk` is the only clock. The core clock is taken to be `clk` divided by two, with its rising edges on the `clk` edges where `core_phase` returns to 0. A core cycle is therefore one phase-0 fast cycle followed by one phase-1 fast cycle. During the phase-0 cycle the adapter steers the port A request onto the RAM. During the phase-1 cycle it steers the port B request. Each port's read data is captured in its own register and held there, so the core sees stable results.

If the RAM cannot run at twice the core rate, the parameter `DOUBLE_RATE` is set to 0. The core then runs on `clk` itself and the adapter arbitrates with wait states. Port A is served first. Port B's ready stays low until B's turn has been served in the following cycle. Requests are qualified by `*_req` and accepted on the clock edge where `*_req` and `*_ready` are both high. A request that is not ready must be held.

Top module: `dpump_ram_adapter`

## Requirements
- R1: The RAM performs at most one operation per `clk` cycle. A write stores `wdata` at `addr`, and a later read of that address returns the stored word.
- R2: `core_phase` is 0 after reset and inverts on every `clk` edge, in both modes.
- R3: With `DOUBLE_RATE`=1, both readies are always 1. A request held by the core across a core cycle is performed for port A at the end of the phase-0 cycle and for port B at the end of the phase-1 cycle.
- R4: Each port's read data register loads the RAM output on the `clk` edge after the edge on which the RAM read for that port, and holds its value otherwise, including across idle cycles and writes. In double-rate mode, `a_rdata` is therefore new from the following phase-0 cycle, and `b_rdata` is new from the following phase-1 cycle.
- R5: When port A writes an address and port B reads that address in the same core cycle (double-rate) or in the same dual request (wait mode), B returns the newly written word.
- R6: When port B writes an address that port A reads in the same core cycle, A returns the old word. When both ports write the same address, B's word is the one kept.
- R7: With `DOUBLE_RATE`=0, a lone request on either port sees its ready high and is accepted at once.
- R8: With `DOUBLE_RATE`=0 and both ports requesting, A is accepted first with `b_ready` low. In the next cycle `a_ready` is low, `b_ready` is high, and B is accepted.
- R9: After reset, both read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM clock (twice the core rate in double-rate mode) |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Port A request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_ready | output | 1 | Port A request accepted this cycle |
| a_rdata | output | DW | Port A held read data |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_ready | output | 1 | Port B request accepted this cycle |
| b_rdata | output | DW | Port B held read data |
| core_phase | output | 1 | Fast-cycle owner: 0 for port A, 1 for port B |

## Verification
The hardest situation to reach is the same-address collision inside one core cycle: a write on one port and a read on the other landing in the two halves of a single slow cycle. Whether the read sees the old or the new word depends only on the fixed phase order. The bench aligns to `core_phase`, drives both ports with the same address for exactly one core cycle, and samples in the phase-0 and phase-1 halves of the following cycle. This separates the A and B capture edges. The wait-state instance is given the same collision through one simultaneous request, which forces the stall.

// File: rtl/dpump_pkg.sv
package dpump_pkg;

  // Which logical port owns the RAM in the current fast cycle.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_A    = 2'd1,
    SLOT_B    = 2'd2
  } slot_e;

  // Double-rate schedule: phase 0 belongs to A, phase 1 to B.
  function automatic slot_e slot_double(input logic ph, input logic ar, input logic br);
    if (!ph && ar) return SLOT_A;
    if (ph && br)  return SLOT_B;
    return SLOT_IDLE;
  endfunction

  // Wait-state schedule: a deferred B goes first, otherwise A wins.
  function automatic slot_e slot_wait(input logic owe_b, input logic ar, input logic br);
    if (owe_b) return br ? SLOT_B : SLOT_IDLE;
    if (ar)    return SLOT_A;
    if (br)    return SLOT_B;
    return SLOT_IDLE;
  endfunction

endpackage

// File: rtl/dpump_spram.sv
module dpump_spram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (en && !we) q <= mem[addr];
  end
endmodule

// File: rtl/dpump_sched.sv
module dpump_sched
  import dpump_pkg::*;
#(
  parameter bit DOUBLE_RATE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_req,
  input  logic  b_req,
  output slot_e slot,
  output logic  a_ready,
  output logic  b_ready,
  output logic  phase
);
  // Fast-cycle owner toggle.
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase != $past(phase)));

  if (DOUBLE_RATE) begin : g_dbl
    assign slot    = slot_double(phase, a_req, b_req);
    assign a_ready = 1'b1;
    assign b_ready = 1'b1;

    p_a_in_phase0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_A) |-> !phase);
    p_b_in_phase1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_B) |-> phase);
  end else begin : g_wait
    logic owe_b;

    always_ff @(posedge clk) begin
      if (!rst_n) owe_b <= 1'b0;
      else        owe_b <= !owe_b && a_req && b_req;
    end

    assign slot    = slot_wait(owe_b, a_req, b_req);
    assign a_ready = !owe_b;
    assign b_ready = owe_b || !a_req;

    p_b_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && b_req && a_ready) |=> (!a_ready && b_ready));
    p_b_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req && b_req && a_ready) |-> (slot == SLOT_A));
  end
endmodule

// File: rtl/dpump_rdhold.sv
module dpump_rdhold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_done,
  input  logic [DW-1:0] ram_q,
  output logic [DW-1:0] data
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      data <= '0;
    end else begin
      pend <= rd_done;
      if (pend) data <= ram_q;
    end
  end

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(data));
endmodule

// File: rtl/dpump_ram_adapter.sv
module dpump_ram_adapter
  import dpump_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter bit DOUBLE_RATE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic          a_ready,
  output logic [DW-1:0] a_rdata,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic          b_ready,
  output logic [DW-1:0] b_rdata,
  output logic          core_phase
);
  localparam int NPORT = 2;

  slot_e         slot;
  logic          ram_en;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_q;
  logic [NPORT-1:0] rd_evt;
  logic [DW-1:0] held [NPORT];

  dpump_sched #(.DOUBLE_RATE(DOUBLE_RATE)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_req   (a_req),
    .b_req   (b_req),
    .slot    (slot),
    .a_ready (a_ready),
    .b_ready (b_ready),
    .phase   (core_phase)
  );

  // Steer the owning port onto the single physical port.
  always_comb begin
    ram_en    = (slot != SLOT_IDLE);
    ram_we    = 1'b0;
    ram_addr  = a_addr;
    ram_wdata = a_wdata;
    if (slot == SLOT_A) begin
      ram_we = a_we;
    end else if (slot == SLOT_B) begin
      ram_we    = b_we;
      ram_addr  = b_addr;
      ram_wdata = b_wdata;
    end
  end

  assign rd_evt[0] = (slot == SLOT_A) && !a_we;
  assign rd_evt[1] = (slot == SLOT_B) && !b_we;

  p_one_reader_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_evt));

  dpump_spram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .q     (ram_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_hold
    dpump_rdhold #(.DW(DW)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_done (rd_evt[p]),
      .ram_q   (ram_q),
      .data    (held[p])
    );
  end

  assign a_rdata = held[0];
  assign b_rdata = held[1];
endmodule

// File: tb/dpump_ram_adapter_tb_top.sv
`timescale 1ns/1ps
module dpump_ram_adapter_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // double-rate instance signals
  logic d_areq = 0, d_awe = 0, d_breq = 0, d_bwe = 0;
  logic [AW-1:0] d_aaddr = '0, d_baddr = '0;
  logic [DW-1:0] d_awd = '0, d_bwd = '0;
  logic d_ardy, d_brdy, d_ph;
  logic [DW-1:0] d_ard, d_brd;

  // wait-state instance signals
  logic w_areq = 0, w_awe = 0, w_breq = 0, w_bwe = 0;
  logic [AW-1:0] w_aaddr = '0, w_baddr = '0;
  logic [DW-1:0] w_awd = '0, w_bwd = '0;
  logic w_ardy, w_brdy, w_ph;
  logic [DW-1:0] w_ard, w_brd;

  dpump_ram_adapter #(.AW(AW), .DW(DW), .DOUBLE_RATE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_req(d_areq), .a_we(d_awe), .a_addr(d_aaddr), .a_wdata(d_awd),
    .a_ready(d_ardy), .a_rdata(d_ard),
    .b_req(d_breq), .b_we(d_bwe), .b_addr(d_baddr), .b_wdata(d_bwd),
    .b_ready(d_brdy), .b_rdata(d_brd), .core_phase(d_ph)
  );

  dpump_ram_adapter #(.AW(AW), .DW(DW), .DOUBLE_RATE(1'b0)) dut_w_i (
    .clk(clk), .rst_n(rst_n),
    .a_req(w_areq), .a_we(w_awe), .a_addr(w_aaddr), .a_wdata(w_awd),
    .a_ready(w_ardy), .a_rdata(w_ard),
    .b_req(w_breq), .b_we(w_bwe), .b_addr(w_baddr), .b_wdata(w_bwd),
    .b_ready(w_brdy), .b_rdata(w_brd), .core_phase(w_ph)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- double-rate helpers ----------------
  task automatic d_align();
    while (d_ph !== 1'b0) @(negedge clk);
  endtask

  // Drive one core cycle of requests, return at phase 0 of the next cycle.
  task automatic d_cycle(input logic ar, input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                         input logic br, input logic bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    d_align();
    d_areq = ar; d_awe = aw; d_aaddr = aa; d_awd = ad;
    d_breq = br; d_bwe = bw; d_baddr = ba; d_bwd = bd;
    @(negedge clk);
    @(negedge clk);
    d_areq = 0; d_breq = 0; d_awe = 0; d_bwe = 0;
  endtask

  // Read both ports, check results in the phase-1 half of the next cycle.
  task automatic d_read2(input logic [AW-1:0] aa, input logic [AW-1:0] ba,
                         input logic [DW-1:0] ea, input logic [DW-1:0] eb, input string tag);
    d_cycle(1, 0, aa, '0, 1, 0, ba, '0);
    @(negedge clk);
    check({tag, " a_rdata"}, 32'(d_ard), 32'(ea));
    check({tag, " b_rdata"}, 32'(d_brd), 32'(eb));
  endtask

  task automatic t_reset();
    check("R9 a_rdata after reset", 32'(d_ard), 32'h0);
    check("R9 b_rdata after reset", 32'(d_brd), 32'h0);
    check("R9 wait a_rdata after reset", 32'(w_ard), 32'h0);
    check("R2 phase after reset", 32'(d_ph), 32'h0);
  endtask

  task automatic t_phase();
    logic prev;
    prev = d_ph;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 phase toggles", 32'(d_ph), 32'(!prev));
      check("R2 wait phase matches", 32'(w_ph), 32'(d_ph));
      prev = d_ph;
    end
  endtask

  task automatic t_basic_dbl();
    check("R3 a_ready high", 32'(d_ardy), 32'h1);
    check("R3 b_ready high", 32'(d_brdy), 32'h1);
    d_cycle(1, 1, 6'd3, 16'h1111, 1, 1, 6'd9, 16'h2222);
    d_read2(6'd9, 6'd3, 16'h2222, 16'h1111, "R1 crossed read");
    d_read2(6'd3, 6'd9, 16'h1111, 16'h2222, "R1 straight read");
  endtask

  task automatic t_timing_dbl();
    // a_rdata new in phase 0 of next cycle, b_rdata still old there (R4)
    d_cycle(1, 0, 6'd9, '0, 1, 0, 6'd3, '0);
    check("R4 a_rdata new in phase0", 32'(d_ard), 32'h2222);
    check("R4 b_rdata old in phase0", 32'(d_brd), 32'h2222);
    @(negedge clk);
    check("R4 b_rdata new in phase1", 32'(d_brd), 32'h1111);
    // idle cycle and write-only cycle leave both outputs unchanged
    d_cycle(0, 0, '0, '0, 0, 0, '0, '0);
    d_cycle(1, 1, 6'd9, 16'h7777, 1, 1, 6'd3, 16'h8888);
    @(negedge clk);
    check("R4 a_rdata held over writes", 32'(d_ard), 32'h2222);
    check("R4 b_rdata held over writes", 32'(d_brd), 32'h1111);
  endtask

  task automatic t_collide_dbl();
    d_cycle(1, 1, 6'd20, 16'hABCD, 1, 0, 6'd20, '0);
    @(negedge clk);
    check("R5 B reads A's new word", 32'(d_brd), 32'hABCD);
    d_cycle(1, 0, 6'd20, '0, 1, 1, 6'd20, 16'h5A5A);
    @(negedge clk);
    check("R6 A reads old word", 32'(d_ard), 32'hABCD);
    d_read2(6'd20, 6'd20, 16'h5A5A, 16'h5A5A, "R6 B write landed");
    d_cycle(1, 1, 6'd33, 16'h0001, 1, 1, 6'd33, 16'h0002);
    d_read2(6'd33, 6'd33, 16'h0002, 16'h0002, "R6 B write wins");
  endtask

  // ---------------- wait-state helpers ----------------
  task automatic w_single(input logic port_b, input logic we, input logic [AW-1:0] ad, input logic [DW-1:0] wd);
    if (port_b) begin w_breq = 1; w_bwe = we; w_baddr = ad; w_bwd = wd; end
    else        begin w_areq = 1; w_awe = we; w_aaddr = ad; w_awd = wd; end
    #1;
    if (port_b) check("R7 lone B ready", 32'(w_brdy), 32'h1);
    else        check("R7 lone A ready", 32'(w_ardy), 32'h1);
    @(negedge clk);
    w_areq = 0; w_breq = 0; w_awe = 0; w_bwe = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic w_both(input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                        input logic bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    w_areq = 1; w_awe = aw; w_aaddr = aa; w_awd = ad;
    w_breq = 1; w_bwe = bw; w_baddr = ba; w_bwd = bd;
    #1;
    check("R8 A ready first", 32'(w_ardy), 32'h1);
    check("R8 B stalled", 32'(w_brdy), 32'h0);
    @(negedge clk);
    w_areq = 0; w_awe = 0;
    #1;
    check("R8 A not ready on B turn", 32'(w_ardy), 32'h0);
    check("R8 B ready on its turn", 32'(w_brdy), 32'h1);
    @(negedge clk);
    w_breq = 0; w_bwe = 0;
    @(negedge clk);
  endtask

  task automatic t_wait();
    w_single(0, 1, 6'd5, 16'hC0DE);
    w_single(1, 1, 6'd6, 16'hBEEF);
    w_single(1, 0, 6'd5, '0);
    check("R7 lone B read", 32'(w_brd), 32'hC0DE);
    w_both(0, 6'd6, '0, 0, 6'd5, '0);
    check("R8 A result", 32'(w_ard), 32'hBEEF);
    check("R8 B result", 32'(w_brd), 32'hC0DE);
    w_both(1, 6'd7, 16'h4321, 0, 6'd7, '0);
    check("R5 wait B sees A write", 32'(w_brd), 32'h4321);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_phase();
    t_basic_dbl();
    t_timing_dbl();
    t_collide_dbl();
    t_wait();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule